// File: doc/BRIEF.md
# Four-Lane Swizzle Permute Unit

This block rearranges the four elements of a short sub-vector under an 8-bit selector. The selector holds one 2-bit source index per output lane. Lane x (output lane 0) reads bits 1:0, lane y reads bits 3:2, lane z reads bits 5:4 and lane w reads bits 7:6. Each index names the input lane whose element is copied. A second mode builds the result from two sources. The two low output lanes pick from the first vector and the two high output lanes pick from the second vector, each lane still using its own 2-bit field. Setting all four fields to the same index broadcasts one element to every lane.

The permute is active only when the sub-vector length input is nonzero. When the length is zero, the first source vector goes to the output unchanged, whatever the selector and mode say. An integer/floating-point flag travels with the data as a tag and has no effect on the data path; the integer and floating-point forms of the operation produce the same bits. One request is accepted per cycle. Its result and the matching valid appear exactly one cycle later. The result registers keep their value in cycles that carry no request.

Top module: `lane_shuffle_unit`

## Requirements
- R1: While reset is asserted (rstN low), outValid is 0, outData is all zeros and outIsFloat is 0.
- R2: outValid in each cycle equals inValid in the cycle before.
- R3: With inValid high, subLen nonzero and dualSrc low, output lane k (lane k occupies outData bits k*ELEM_W and up) in the next cycle equals the srcA lane named by selCode bits 2k+1:2k.
- R4: With inValid high, subLen nonzero and dualSrc high, output lanes 0 and 1 take the srcA lane named by their selector field, and output lanes 2 and 3 take the srcB lane named by their selector field.
- R5: With inValid high and subLen zero, outData in the next cycle equals srcA, whatever selCode and dualSrc hold.
- R6: In single-source mode with subLen nonzero, if all four selector fields hold the same index, every output lane holds that one srcA element.
- R7: outIsFloat in the cycle after an accepted request equals that request's isFloat. For the same operands, outData is the same whether isFloat is 0 or 1.
- R8: In a cycle after one with inValid low, outData keeps its previous value.
- R9: In single-source mode, srcB has no effect on outData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request present this cycle |
| srcA | input | 4*ELEM_W | First source vector; lane k at bits k*ELEM_W and up |
| srcB | input | 4*ELEM_W | Second source vector, read only in dual-source mode |
| selCode | input | 8 | Four 2-bit lane source indices, lane 0 in bits 1:0 |
| dualSrc | input | 1 | 1 selects two-source mode |
| isFloat | input | 1 | Floating-point tag carried to the output |
| subLen | input | SUBLEN_W | Sub-vector length; zero bypasses the permute |
| outValid | output | 1 | Result valid |
| outData | output | 4*ELEM_W | Permuted vector |
| outIsFloat | output | 1 | Tag of the request the result belongs to |

## Verification
The bench targets several corner cases, each tied to a likely defect:
- Reversed and identity selectors catch a design that reads the 2-bit fields in the wrong order; such a design would mirror the lanes.
- Broadcast selectors catch an index that is decoded from the lane number instead of from the field.
- A zero sub-vector length with a scrambled selector and with the dual-source bit set catches a bypass that is missing or only partly applied.
- Dual-source requests with srcB unlike srcA catch lanes 2 and 3 being drawn from the wrong vector.
- Changing srcB in single-source mode catches a leak from the second input.
- Idle cycles catch results that are overwritten or cleared when no request arrives.
- Repeating an operation with the float flag flipped catches a tag that alters the data.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;
  // Lane count is fixed by the 8-bit selector: four 2-bit indices.
  localparam int LANE_CNT = 4;
  localparam int IDX_W    = $clog2(LANE_CNT);
  localparam int SEL_W    = LANE_CNT * IDX_W;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // capture a new result this cycle
    logic bypass;  // sub-vector length zero: pass srcA straight through
    logic dual;    // high lanes draw from the second source
  } shuf_strobe_t;
endpackage

// File: rtl/lane_shuffle_ctrl.sv
module lane_shuffle_ctrl
  import lane_shuffle_pkg::*;
#(
  parameter int SUBLEN_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SUBLEN_W-1:0] subLen,
  input  logic                dualSrc,
  input  logic                isFloat,
  output shuf_strobe_t        strobe,
  output logic                outValid,
  output logic                outIsFloat
);
  logic lenZero;

  always_comb begin
    lenZero       = (subLen == '0);
    strobe.load   = inValid;
    strobe.bypass = lenZero;
    strobe.dual   = dualSrc & ~lenZero;
  end

  // Valid tracks the request with one register stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

  // Tag is only a label; it follows the data it belongs to.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outIsFloat <= 1'b0;
    end else if (inValid) begin
      outIsFloat <= isFloat;
    end
  end
endmodule

// File: rtl/lane_shuffle_datapath.sv
module lane_shuffle_datapath
  import lane_shuffle_pkg::*;
#(
  parameter int ELEM_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  shuf_strobe_t               strobe,
  input  logic [LANE_CNT*ELEM_W-1:0] srcA,
  input  logic [LANE_CNT*ELEM_W-1:0] srcB,
  input  logic [SEL_W-1:0]           selCode,
  output logic [LANE_CNT*ELEM_W-1:0] outData
);
  localparam int HALF = LANE_CNT / 2;

  logic [ELEM_W-1:0] elemA [LANE_CNT];
  logic [ELEM_W-1:0] elemB [LANE_CNT];

  always_comb begin
    for (int i = 0; i < LANE_CNT; i++) begin
      elemA[i] = srcA[i*ELEM_W +: ELEM_W];
      elemB[i] = srcB[i*ELEM_W +: ELEM_W];
    end
  end

  for (genvar lane = 0; lane < LANE_CNT; lane++) begin : g_lane
    logic [IDX_W-1:0]  fieldIdx;
    logic [ELEM_W-1:0] swizVal;
    logic [ELEM_W-1:0] nextVal;
    logic [ELEM_W-1:0] laneQ;

    assign fieldIdx = selCode[lane*IDX_W +: IDX_W];

    if (lane >= HALF) begin : g_high
      // High lanes may switch to the second source.
      always_comb begin
        swizVal = strobe.dual ? elemB[fieldIdx] : elemA[fieldIdx];
      end
    end else begin : g_low
      always_comb begin
        swizVal = elemA[fieldIdx];
      end
    end

    always_comb begin
      nextVal = strobe.bypass ? elemA[lane] : swizVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (strobe.load) begin
        laneQ <= nextVal;
      end
    end

    assign outData[lane*ELEM_W +: ELEM_W] = laneQ;
  end
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
  import lane_shuffle_pkg::*;
#(
  parameter int ELEM_W   = 32,
  parameter int SUBLEN_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [LANE_CNT*ELEM_W-1:0] srcA,
  input  logic [LANE_CNT*ELEM_W-1:0] srcB,
  input  logic [SEL_W-1:0]           selCode,
  input  logic                       dualSrc,
  input  logic                       isFloat,
  input  logic [SUBLEN_W-1:0]        subLen,
  output logic                       outValid,
  output logic [LANE_CNT*ELEM_W-1:0] outData,
  output logic                       outIsFloat
);
  shuf_strobe_t strobe;

  lane_shuffle_ctrl #(.SUBLEN_W(SUBLEN_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .subLen    (subLen),
    .dualSrc   (dualSrc),
    .isFloat   (isFloat),
    .strobe    (strobe),
    .outValid  (outValid),
    .outIsFloat(outIsFloat)
  );

  lane_shuffle_datapath #(.ELEM_W(ELEM_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .srcA   (srcA),
    .srcB   (srcB),
    .selCode(selCode),
    .outData(outData)
  );
endmodule

// File: rtl/lane_shuffle_checker.sv
module lane_shuffle_checker
  import lane_shuffle_pkg::*;
#(
  parameter int ELEM_W   = 32,
  parameter int SUBLEN_W = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic [LANE_CNT*ELEM_W-1:0] srcA,
  input logic [LANE_CNT*ELEM_W-1:0] srcB,
  input logic [SEL_W-1:0]           selCode,
  input logic                       dualSrc,
  input logic                       isFloat,
  input logic [SUBLEN_W-1:0]        subLen,
  input logic                       outValid,
  input logic [LANE_CNT*ELEM_W-1:0] outData,
  input logic                       outIsFloat
);
  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  function automatic logic [ELEM_W-1:0] elemOf(logic [LANE_CNT*ELEM_W-1:0] v,
                                                logic [IDX_W-1:0] idx);
    return v[idx*ELEM_W +: ELEM_W];
  endfunction

  logic allSame;
  assign allSame = (selCode[1:0] == selCode[3:2]) && (selCode[3:2] == selCode[5:4])
                && (selCode[5:4] == selCode[7:6]);

  always_comb begin
    if (!rstN) begin
      a_reset_r1: assert (outValid == 1'b0 || $time == 0);
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> outValid == $past(inValid));

  p_lane0_r3: assert property (@(posedge clk) disable iff (!rstN)
    primed && inValid && subLen != '0 |=>
      elemOf(outData, 2'd0) == elemOf($past(srcA), $past(selCode[1:0])));

  p_dual_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    primed && inValid && subLen != '0 && dualSrc |=>
      elemOf(outData, 2'd3) == elemOf($past(srcB), $past(selCode[7:6])));

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    primed && inValid && subLen == '0 |=> outData == $past(srcA));

  p_broadcast_r6: assert property (@(posedge clk) disable iff (!rstN)
    primed && inValid && subLen != '0 && !dualSrc && allSame |=>
      elemOf(outData, 2'd0) == elemOf(outData, 2'd1) &&
      elemOf(outData, 2'd1) == elemOf(outData, 2'd2) &&
      elemOf(outData, 2'd2) == elemOf(outData, 2'd3));

  p_tag_r7: assert property (@(posedge clk) disable iff (!rstN)
    primed && inValid |=> outIsFloat == $past(isFloat));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    primed && !inValid |=> $stable(outData));

  p_single_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    primed && inValid && subLen != '0 && !dualSrc |=>
      elemOf(outData, 2'd3) == elemOf($past(srcA), $past(selCode[7:6])));
endmodule

bind lane_shuffle_unit lane_shuffle_checker #(.ELEM_W(ELEM_W), .SUBLEN_W(SUBLEN_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .srcA      (srcA),
  .srcB      (srcB),
  .selCode   (selCode),
  .dualSrc   (dualSrc),
  .isFloat   (isFloat),
  .subLen    (subLen),
  .outValid  (outValid),
  .outData   (outData),
  .outIsFloat(outIsFloat)
);

// File: tb/tb_lane_shuffle_unit.sv
`timescale 1ns/1ps
module tb_lane_shuffle_unit;
  import lane_shuffle_pkg::*;
  localparam int EW = 32;
  localparam int SW = 2;
  localparam int DW = LANE_CNT * EW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] srcA = '0;
  logic [DW-1:0] srcB = '0;
  logic [7:0]    selCode = '0;
  logic          dualSrc = 1'b0;
  logic          isFloat = 1'b0;
  logic [SW-1:0] subLen = '0;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          outIsFloat;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] expData = '0;
  logic          expTag = 1'b0;

  always #2.5 clk = ~clk;

  lane_shuffle_unit #(.ELEM_W(EW), .SUBLEN_W(SW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .selCode(selCode), .dualSrc(dualSrc), .isFloat(isFloat), .subLen(subLen),
    .outValid(outValid), .outData(outData), .outIsFloat(outIsFloat)
  );

  function automatic logic [DW-1:0] model(logic [DW-1:0] a, logic [DW-1:0] b,
                                          logic [7:0] sel, logic dual, logic [SW-1:0] len);
    logic [DW-1:0] r;
    if (len == '0) return a;
    for (int l = 0; l < LANE_CNT; l++) begin
      int idx;
      idx = int'(sel[2*l +: 2]);
      if (dual && l >= 2) r[l*EW +: EW] = b[idx*EW +: EW];
      else                r[l*EW +: EW] = a[idx*EW +: EW];
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] randVec();
    logic [DW-1:0] v;
    for (int l = 0; l < LANE_CNT; l++) v[l*EW +: EW] = EW'($urandom);
    return v;
  endfunction

  task automatic check(string req, logic expV);
    checks++;
    if (outValid !== expV || outData !== expData || outIsFloat !== expTag) begin
      fails++;
      $display("FAIL %s: got v=%0b d=%h f=%0b, expected v=%0b d=%h f=%0b",
               req, outValid, outData, outIsFloat, expV, expData, expTag);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic apply(string req, logic v, logic [DW-1:0] a, logic [DW-1:0] b,
                       logic [7:0] sel, logic dual, logic [SW-1:0] len, logic fp);
    inValid = v; srcA = a; srcB = b; selCode = sel; dualSrc = dual;
    subLen = len; isFloat = fp;
    if (v) begin
      expData = model(a, b, sel, dual, len);
      expTag  = fp;
    end
    @(negedge clk);
    check(req, v);
  endtask

  logic [DW-1:0] vecA;
  logic [DW-1:0] vecB;
  logic [DW-1:0] saved;

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5eed);
    vecA = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
    vecB = {32'h44440013, 32'h33330012, 32'h22220011, 32'h11110010};
    repeat (3) @(negedge clk);
    check("R1", 1'b0);  // reset state
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    apply("R3", 1'b1, vecA, vecB, 8'hE4, 1'b0, 2'd1, 1'b0);  // identity
    apply("R3", 1'b1, vecA, vecB, 8'h1B, 1'b0, 2'd3, 1'b0);  // reversed
    apply("R6", 1'b1, vecA, vecB, 8'h55, 1'b0, 2'd2, 1'b0);  // broadcast lane 1
    apply("R6", 1'b1, vecA, vecB, 8'hFF, 1'b0, 2'd1, 1'b0);  // broadcast lane 3
    apply("R4", 1'b1, vecA, vecB, 8'h1B, 1'b1, 2'd1, 1'b0);
    apply("R4", 1'b1, vecA, vecB, 8'hE4, 1'b1, 2'd2, 1'b1);
    apply("R5", 1'b1, vecA, vecB, 8'h1B, 1'b0, 2'd0, 1'b0);
    apply("R5", 1'b1, vecB, vecA, 8'h93, 1'b1, 2'd0, 1'b0);
    // R9: second source changed, result must match
    apply("R9", 1'b1, vecA, vecB, 8'h6C, 1'b0, 2'd1, 1'b0);
    saved = outData;
    apply("R9", 1'b1, vecA, ~vecB, 8'h6C, 1'b0, 2'd1, 1'b0);
    checks++;
    if (outData !== saved) begin
      fails++;
      $display("FAIL R9: got %h, expected %h", outData, saved);
    end
    // R7: flag flip leaves data unchanged
    apply("R7", 1'b1, vecA, vecB, 8'h27, 1'b1, 2'd3, 1'b1);
    saved = outData;
    apply("R7", 1'b1, vecA, vecB, 8'h27, 1'b1, 2'd3, 1'b0);
    checks++;
    if (outData !== saved) begin
      fails++;
      $display("FAIL R7: got %h, expected %h", outData, saved);
    end
    // R8 / R2: idle cycles with scrambled inputs hold the result
    apply("R8", 1'b0, vecB, vecA, 8'h00, 1'b0, 2'd0, 1'b1);
    apply("R2", 1'b0, ~vecA, vecB, 8'hFF, 1'b1, 2'd3, 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic v;
      logic dual;
      logic [SW-1:0] len;
      logic [7:0] sel;
      v    = ($urandom % 4) != 0;
      dual = 1'($urandom);
      len  = SW'($urandom);
      sel  = 8'($urandom);
      if (!v)            apply("R8", v, randVec(), randVec(), sel, dual, len, 1'($urandom));
      else if (len == 0) apply("R5", v, randVec(), randVec(), sel, dual, len, 1'($urandom));
      else if (dual)     apply("R4", v, randVec(), randVec(), sel, dual, len, 1'($urandom));
      else               apply("R3", v, randVec(), randVec(), sel, dual, len, 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL R2: watchdog expired, got no completion, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule